// File: doc/BRIEF.md
# Exception Vector Relocation Unit

This block sits on the instruction-fetch address path of a processor core. When relocation is switched on, a fetch that lands on an exception vector in the high region starting at 0xFFF0_0000 is steered into a compact relocation page. Vectors there are spaced 256 bytes apart. In the page each vector gets an 8-byte slot. A 2-bit selector picks the page base. An internal-space offset, a multiple of 4 MiB, is added to that base.

In enhanced external-interrupt mode the fetch of the external interrupt vector takes a different route. It goes to an entry in a relocation table instead of its normal slot. The table base comes from a base register. The entry index is the highest-priority vector from the interrupt controller. The block latches that vector when the core acknowledges the interrupt, so a later change in priority cannot disturb a fetch already under way.

All address translation is combinational. The only state is the latched interrupt vector.

Top module: `exc_vec_reloc`

## Requirements
- R1: While `reloc_en` is low, `xlat_addr` equals `fetch_addr` and `reloc_hit` is low.
- R2: An address outside 0xFFF0_0000..0xFFF0_1FFF passes through unchanged with `reloc_hit` low. So does an address in that window whose bits [7:0] are not all zero.
- R3: A vector hit at 0xFFF0_0000 + N*0x100 (N in 0..31) gives `xlat_addr` = page base + N*8, with `reloc_hit` high. For example, 0x1300 goes to base+0x098 and 0x1F00 goes to base+0x0F8.
- R4: `page_sel` encoding for the page base: 2'b00 gives 0x0, 2'b01 gives 0x1_0000, 2'b10 gives 0x8_0000, 2'b11 gives 0x3F_E000.
- R5: The page base also includes `isb` * 0x40_0000.
- R6: With `eirq_mode_en` high, a hit on 0xFFF0_0500 gives `tbl_base` + latched_vector*8, with `reloc_hit` high.
- R7: The latched vector takes `irq_vector` on a clock edge where `irq_ack` is high. It holds its value otherwise, and synchronous reset clears it to 0.
- R8: With `eirq_mode_en` low, 0xFFF0_0500 relocates like any other vector, to base+0x028.
- R9: While `fetch_valid` is low, `xlat_addr` equals `fetch_addr` and `reloc_hit` is low.
- R10: Translation is combinational, so outputs follow inputs within the same cycle. A newly latched vector affects outputs from the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | input | 32 | Fetch address from the core |
| fetch_valid | input | 1 | Fetch address is valid |
| reloc_en | input | 1 | Enables vector relocation |
| page_sel | input | 2 | Relocation page selector |
| isb | input | ISB_W (3) | Internal-space block number |
| eirq_mode_en | input | 1 | Enables enhanced external-interrupt redirect |
| tbl_base | input | 32 | Physical base of the interrupt relocation table |
| irq_vector | input | VEC_W (8) | Current highest-priority vector from the interrupt controller |
| irq_ack | input | 1 | Core acknowledges the interrupt; latch the vector |
| xlat_addr | output | 32 | Translated fetch address |
| reloc_hit | output | 1 | Address was relocated |

## Verification
Every address result is due in the cycle its inputs change. The bench drives on the falling edge and samples one nanosecond later, before any rising edge can get involved. The latched vector is the only result with a delay. The bench raises `irq_ack` on a falling edge, waits for the next rising edge, and only then checks the redirected table address at the following falling edge. It also checks that dropping `irq_ack` and changing `irq_vector` leaves the redirect where it was.

// File: rtl/evr_pkg.sv
package evr_pkg;

    localparam int          ADDR_W        = 32;
    localparam logic [31:0] VEC_REGION    = 32'hFFF0_0000;
    localparam int          WIN_LSB       = 13;
    localparam int          SLOT_LSB      = 8;
    localparam int          SLOT_SHIFT    = 3;
    localparam int          ISB_SHIFT     = 22;
    localparam int          ENTRY_SHIFT   = 3;
    localparam logic [12:0] EXT_IRQ_OFF   = 13'h0500;
    localparam int          SLOT_IDX_W    = WIN_LSB - SLOT_LSB;
    localparam int          SLOT_OFF_W    = SLOT_IDX_W + SLOT_SHIFT;

    typedef enum logic [1:0] {
        PG_ZERO  = 2'b00,
        PG_64K   = 2'b01,
        PG_512K  = 2'b10,
        PG_TOP   = 2'b11
    } page_sel_e;

    typedef struct packed {
        logic                  in_window;
        logic                  is_ext;
        logic [SLOT_OFF_W-1:0] slot_off;
    } vec_hit_t;

    function automatic logic [ADDR_W-1:0] page_offset(page_sel_e s);
        case (s)
            PG_ZERO: page_offset = 32'h0000_0000;
            PG_64K:  page_offset = 32'h0001_0000;
            PG_512K: page_offset = 32'h0008_0000;
            default: page_offset = 32'h003F_E000;
        endcase
    endfunction

endpackage

// File: rtl/evr_vec_decode.sv
module evr_vec_decode
    import evr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output vec_hit_t          dec
);
    logic win_match;
    logic low_zero;

    always_comb begin
        win_match    = (addr[ADDR_W-1:WIN_LSB] == VEC_REGION[ADDR_W-1:WIN_LSB]);
        low_zero     = (addr[SLOT_LSB-1:0] == '0);
        dec.in_window = win_match && low_zero;
        dec.is_ext    = dec.in_window && (addr[WIN_LSB-1:0] == EXT_IRQ_OFF);
        dec.slot_off  = {addr[WIN_LSB-1:SLOT_LSB], {SLOT_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/evr_page_gen.sv
module evr_page_gen
    import evr_pkg::*;
#(
    parameter int ISB_W = 3
) (
    input  logic [1:0]        page_sel,
    input  logic [ISB_W-1:0]  isb,
    output logic [ADDR_W-1:0] page_base
);
    logic [ADDR_W-1:0] isb_off;

    always_comb begin
        isb_off   = ADDR_W'(isb) << ISB_SHIFT;
        page_base = page_offset(page_sel_e'(page_sel)) + isb_off;
    end
endmodule

// File: rtl/evr_vec_capture.sv
module evr_vec_capture #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_ack,
    input  logic [VEC_W-1:0] irq_vector,
    output logic [VEC_W-1:0] held_vec
);
    always_ff @(posedge clk) begin
        if (rst)          held_vec <= '0;
        else if (irq_ack) held_vec <= irq_vector;
    end

    AST_VEC_LATCH: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> held_vec == $past(irq_vector)); // R7
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !irq_ack |=> $stable(held_vec)); // R7
endmodule

// File: rtl/exc_vec_reloc.sv
module exc_vec_reloc
    import evr_pkg::*;
#(
    parameter int ISB_W = 3,
    parameter int VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       fetch_addr,
    input  logic              fetch_valid,
    input  logic              reloc_en,
    input  logic [1:0]        page_sel,
    input  logic [ISB_W-1:0]  isb,
    input  logic              eirq_mode_en,
    input  logic [31:0]       tbl_base,
    input  logic [VEC_W-1:0]  irq_vector,
    input  logic              irq_ack,
    output logic [31:0]       xlat_addr,
    output logic              reloc_hit
);
    vec_hit_t          dec;
    logic [ADDR_W-1:0] page_base;
    logic [VEC_W-1:0]  held_vec;
    logic [ADDR_W-1:0] tbl_addr;
    logic [ADDR_W-1:0] slot_addr;
    logic              active;

    evr_vec_decode u_dec (
        .addr (fetch_addr),
        .dec  (dec)
    );

    evr_page_gen #(.ISB_W(ISB_W)) u_page (
        .page_sel  (page_sel),
        .isb       (isb),
        .page_base (page_base)
    );

    evr_vec_capture #(.VEC_W(VEC_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .irq_ack    (irq_ack),
        .irq_vector (irq_vector),
        .held_vec   (held_vec)
    );

    always_comb begin
        active    = fetch_valid && reloc_en && dec.in_window;
        tbl_addr  = tbl_base + (ADDR_W'(held_vec) << ENTRY_SHIFT);
        slot_addr = page_base + ADDR_W'(dec.slot_off);
        xlat_addr = fetch_addr;
        reloc_hit = 1'b0;
        if (active) begin
            reloc_hit = 1'b1;
            xlat_addr = (eirq_mode_en && dec.is_ext) ? tbl_addr : slot_addr;
        end
    end

    AST_PASS_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !reloc_en |-> (xlat_addr == fetch_addr) && !reloc_hit); // R1
    AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        reloc_hit |-> (fetch_addr[31:13] == 19'h7FF80) && (fetch_addr[7:0] == 8'h00)); // R2
    AST_PASS_INVALID: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |-> (xlat_addr == fetch_addr) && !reloc_hit); // R9
    AST_SLOT_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        (reloc_hit && !(eirq_mode_en && fetch_addr[12:0] == 13'h0500))
        |-> (xlat_addr - page_base) < 32'h100); // R3
endmodule

// File: tb/test_exc_vec_reloc.sv
module test_exc_vec_reloc;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fetch_addr;
    logic        fetch_valid;
    logic        reloc_en;
    logic [1:0]  page_sel;
    logic [2:0]  isb;
    logic        eirq_mode_en;
    logic [31:0] tbl_base;
    logic [7:0]  irq_vector;
    logic        irq_ack;
    logic [31:0] xlat_addr;
    logic        reloc_hit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    exc_vec_reloc i_exc_vec_reloc (
        .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
        .reloc_en(reloc_en), .page_sel(page_sel), .isb(isb),
        .eirq_mode_en(eirq_mode_en), .tbl_base(tbl_base), .irq_vector(irq_vector),
        .irq_ack(irq_ack), .xlat_addr(xlat_addr), .reloc_hit(reloc_hit)
    );

    function automatic logic [31:0] base_of(logic [1:0] s, logic [2:0] b);
        logic [31:0] p;
        case (s)
            2'b00: p = 32'h0;
            2'b01: p = 32'h1_0000;
            2'b10: p = 32'h8_0000;
            default: p = 32'h3F_E000;
        endcase
        return p + 32'(b) * 32'h40_0000;
    endfunction

    task automatic check(string req, logic [31:0] exp_a, logic exp_h);
        n_chk++;
        if (xlat_addr !== exp_a || reloc_hit !== exp_h) begin
            n_bad++;
            $display("FAIL %s: addr=%h hit=%b expected addr=%h hit=%b",
                     req, xlat_addr, reloc_hit, exp_a, exp_h);
        end
    endtask

    task automatic apply(logic [31:0] a);
        @(negedge clk);
        fetch_addr = a;
        #1;
    endtask

    task automatic t_reset_state;
        eirq_mode_en = 1'b1; reloc_en = 1'b1; page_sel = 2'b00; isb = 3'd0;
        tbl_base = 32'h0002_0000;
        apply(32'hFFF0_0500);
        check("R7 reset vector zero", 32'h0002_0000, 1'b1);
        eirq_mode_en = 1'b0;
    endtask

    task automatic t_disabled;
        reloc_en = 1'b0;
        apply(32'hFFF0_1300);
        check("R1", 32'hFFF0_1300, 1'b0);
        reloc_en = 1'b1;
    endtask

    task automatic t_invalid;
        fetch_valid = 1'b0;
        apply(32'hFFF0_1C00);
        check("R9", 32'hFFF0_1C00, 1'b0);
        fetch_valid = 1'b1;
    endtask

    task automatic t_nonvector;
        apply(32'hFFF0_1310);
        check("R2 low byte", 32'hFFF0_1310, 1'b0);
        apply(32'hFFF0_2000);
        check("R2 above window", 32'hFFF0_2000, 1'b0);
        apply(32'h0000_1300);
        check("R2 low address", 32'h0000_1300, 1'b0);
    endtask

    task automatic t_slots;
        page_sel = 2'b00; isb = 3'd0;
        for (int n = 0; n < 32; n++) begin
            apply(32'hFFF0_0000 + 32'(n) * 32'h100);
            check("R3 R10 slot", 32'(n) * 8, 1'b1);
        end
        apply(32'hFFF0_1400);
        check("R3 0x1400", 32'h0A0, 1'b1);
    endtask

    task automatic t_pages;
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 8; b += 3) begin
                page_sel = 2'(s); isb = 3'(b);
                apply(32'hFFF0_1E00);
                check("R4 R5 page", base_of(2'(s), 3'(b)) + 32'h0F0, 1'b1);
            end
        end
        page_sel = 2'b00; isb = 3'd0;
    endtask

    task automatic t_ext_normal;
        eirq_mode_en = 1'b0; page_sel = 2'b10; isb = 3'd1;
        apply(32'hFFF0_0500);
        check("R8", base_of(2'b10, 3'd1) + 32'h028, 1'b1);
    endtask

    task automatic t_ext_redirect;
        eirq_mode_en = 1'b1; tbl_base = 32'h0040_8000;
        @(negedge clk); irq_vector = 8'h2D; irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0; irq_vector = 8'h07;
        apply(32'hFFF0_0500);
        check("R6 R7 latch", 32'h0040_8000 + 32'h2D * 8, 1'b1);
        repeat (3) @(negedge clk);
        #1;
        check("R7 hold", 32'h0040_8000 + 32'h2D * 8, 1'b1);
        apply(32'hFFF0_0600);
        check("R6 other vector", base_of(2'b10, 3'd1) + 32'h030, 1'b1);
        @(negedge clk); irq_vector = 8'hFF; irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        apply(32'hFFF0_0500);
        check("R6 max vector", 32'h0040_8000 + 32'hFF * 8, 1'b1);
    endtask

    initial begin
        rst = 1'b1; fetch_addr = '0; fetch_valid = 1'b1; reloc_en = 1'b0;
        page_sel = '0; isb = '0; eirq_mode_en = 1'b0; tbl_base = '0;
        irq_vector = '0; irq_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset_state();
        t_disabled();
        t_invalid();
        t_nonvector();
        t_slots();
        t_pages();
        t_ext_normal();
        t_ext_redirect();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule